// File: doc/BRIEF.md
# ADC Scan Start Trigger Selector

This block decides, cycle by cycle, whether an analog-to-digital scan sequencer should begin a scan. A 16-bit select register names one synchronous start source for a primary group (A) and one for a secondary group (B). Each name is an index into a vector of single-clock trigger sources. The block qualifies the chosen source with a trigger-enable input, an external-select input and the current scan mode. It also accepts a software start request. It issues at most one registered start pulse per cycle, either for group A or for group B.

Group A is the only group used in single and continuous scan modes. Group B takes part only in group scan mode. It can be started only by a synchronous source or by its self-restart code; software and asynchronous starts never reach it. An asynchronous external trigger input is brought into the clock domain by a flop chain, and its rising edge is used as a group A source. Any request that arrives while the sequencer reports busy is discarded rather than held. Requests are also discarded in the cycle right after a start, which gives the busy flag one cycle to rise.

Top module: `adc_start_sel`

## Requirements
- R1: During and after reset, the register reads 0x0000 and both start outputs are low.
- R2: A write stores the data with bits 15:14 and 7:6 forced to zero. A read always returns the stored value, so it equals the written value AND 0x3F3F. Bits 13:8 select the group A source and bits 5:0 select the group B source.
- R3: When `swStart` is high, `startA` pulses on the next clock edge, whatever the values of `trgEnable`, `extSelect` and the group A field.
- R4: A synchronous source gives a `startA` pulse on the next edge only when `syncSrc[groupA field]` is 1, `trgEnable` is 1 and `extSelect` is 0. This holds in every scan mode.
- R5: With `trgEnable`=1 and `extSelect`=1, a rising edge of `asyncTrig` gives exactly one `startA` pulse, on the third clock edge that samples it high, even if the input stays high. With `extSelect`=0, `asyncTrig` has no effect.
- R6: `startB` can pulse only when `scanMode` is 2'b10 (group scan). The codes 2'b00 (single), 2'b01 (continuous) and 2'b11 never produce `startB`.
- R7: A group B field of 0 never produces `startB`. `swStart` and `asyncTrig` never produce `startB`.
- R8: When the group B field is 0x3F, the mode is group scan and `trgEnable`=1, `startB` pulses on every cycle that is not blocked, without any source. For group B fields 1 to 62, `startB` also needs `syncSrc[groupB field]`=1 and `extSelect`=0.
- R9: While `scanBusy` is high, every request is discarded. Discarded requests are not remembered and produce no later pulse.
- R10: When group A and group B requests arrive in the same cycle, only `startA` pulses. The group B request is discarded.
- R11: Each start output is a single-cycle pulse. In the cycle after any start pulse, neither output can pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the select register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Current register contents |
| trgEnable | input | 1 | Enables hardware start sources |
| extSelect | input | 1 | 1: asynchronous input drives group A; 0: synchronous sources |
| scanMode | input | 2 | 00 single, 01 continuous, 10 group scan, 11 reserved |
| swStart | input | 1 | Software start request for group A |
| asyncTrig | input | 1 | Asynchronous external trigger level |
| syncSrc | input | NUM_SRC | Synchronous trigger sources, indexed by the select fields |
| scanBusy | input | 1 | Sequencer busy; discards requests |
| startA | output | 1 | Group A start pulse |
| startB | output | 1 | Group B start pulse |

## Verification
Software and synchronous requests show up on the start outputs one edge after they are applied. An asynchronous edge needs three edges: two flops in the synchronizer plus the output register. The bench applies each stimulus right after a rising edge. It steps exactly that number of edges and samples one time unit after the edge in which the pulse is due. Between cases it idles for two cycles, so that the one-cycle block after a pulse never overlaps the next case. The sweep covers all 64 group A codes under every enable and select combination.

// File: rtl/adc_trg_pkg.sv
package adc_trg_pkg;
  localparam int SEL_W = 6;
  localparam logic [15:0] REG_MASK = 16'h3F3F;
  localparam logic [SEL_W-1:0] SEL_NONE = '0;
  localparam logic [SEL_W-1:0] SEL_AUTO = '1;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_CONT   = 2'b01,
    MODE_GROUP  = 2'b10,
    MODE_RSVD   = 2'b11
  } scanMode_e;

  // raw hits from datapath to control
  typedef struct packed {
    logic swHit;
    logic syncHitA;
    logic asyncEdge;
    logic syncHitB;
    logic selBNone;
    logic selBAuto;
  } trgHits_t;
endpackage

// File: rtl/adc_trg_dp.sv
module adc_trg_dp
  import adc_trg_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [15:0]        regWrData,
  output logic [15:0]        regRdData,
  input  logic               swStart,
  input  logic               asyncTrig,
  input  logic [NUM_SRC-1:0] syncSrc,
  output trgHits_t           hits
);
  localparam int PAD_N = 1 << SEL_W;

  logic [15:0]        selReg;
  logic [SEL_W-1:0]   selA;
  logic [SEL_W-1:0]   selB;
  logic [PAD_N-1:0]   srcPad;
  logic [SYNC_STAGES:0] syncChain;

  always_ff @(posedge clk) begin
    if (!rstN)        selReg <= '0;
    else if (regWrEn) selReg <= regWrData & REG_MASK;
  end

  assign regRdData = selReg;
  assign selA = selReg[13:8];
  assign selB = selReg[5:0];

  // indices past NUM_SRC read as never firing
  always_comb begin
    srcPad = '0;
    srcPad[NUM_SRC-1:0] = syncSrc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], asyncTrig};
  end

  always_comb begin
    hits.swHit     = swStart;
    hits.syncHitA  = srcPad[selA];
    hits.asyncEdge = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];
    hits.syncHitB  = srcPad[selB];
    hits.selBNone  = (selB == SEL_NONE);
    hits.selBAuto  = (selB == SEL_AUTO);
  end
endmodule

// File: rtl/adc_trg_ctrl.sv
module adc_trg_ctrl
  import adc_trg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  trgHits_t  hits,
  input  logic      trgEnable,
  input  logic      extSelect,
  input  scanMode_e mode,
  input  logic      scanBusy,
  output logic      startA,
  output logic      startB
);
  logic reqA;
  logic reqB;
  logic bAllowed;
  logic gateOpen;

  always_comb begin
    reqA = hits.swHit
         | (trgEnable & ~extSelect & hits.syncHitA)
         | (trgEnable &  extSelect & hits.asyncEdge);
    bAllowed = (mode == MODE_GROUP) & trgEnable & ~hits.selBNone;
    reqB = bAllowed & (hits.selBAuto | (~extSelect & hits.syncHitB));
    gateOpen = ~scanBusy & ~(startA | startB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startA <= 1'b0;
      startB <= 1'b0;
    end else begin
      startA <= reqA & gateOpen;
      startB <= reqB & gateOpen & ~reqA;
    end
  end
endmodule

// File: rtl/adc_start_sel.sv
module adc_start_sel
  import adc_trg_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [15:0]        regWrData,
  output logic [15:0]        regRdData,
  input  logic               trgEnable,
  input  logic               extSelect,
  input  logic [1:0]         scanMode,
  input  logic               swStart,
  input  logic               asyncTrig,
  input  logic [NUM_SRC-1:0] syncSrc,
  input  logic               scanBusy,
  output logic               startA,
  output logic               startB
);
  trgHits_t hits;

  adc_trg_dp #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .swStart   (swStart),
    .asyncTrig (asyncTrig),
    .syncSrc   (syncSrc),
    .hits      (hits)
  );

  adc_trg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hits      (hits),
    .trgEnable (trgEnable),
    .extSelect (extSelect),
    .mode      (scanMode_e'(scanMode)),
    .scanBusy  (scanBusy),
    .startA    (startA),
    .startB    (startB)
  );
endmodule

// File: rtl/adc_trg_chk.sv
module adc_trg_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] regRdData,
  input logic [1:0]  scanMode,
  input logic        scanBusy,
  input logic        startA,
  input logic        startB
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[15:14] == 2'b00) && (regRdData[7:6] == 2'b00));

  p_b_only_group_r6: assert property (@(posedge clk) disable iff (!rstN)
    (scanMode != 2'b10) |=> !startB);

  p_b_none_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[5:0] == 6'd0) |=> !startB);

  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    scanBusy |=> (!startA && !startB));

  p_one_group_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(startA && startB));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    (startA || startB) |=> (!startA && !startB));
endmodule

bind adc_start_sel adc_trg_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regRdData (regRdData),
  .scanMode  (scanMode),
  .scanBusy  (scanBusy),
  .startA    (startA),
  .startB    (startB)
);

// File: tb/sim_adc_start_sel.sv
module sim_adc_start_sel;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rstN;
  logic          regWrEn;
  logic [15:0]   regWrData;
  logic [15:0]   regRdData;
  logic          trgEnable;
  logic          extSelect;
  logic [1:0]    scanMode;
  logic          swStart;
  logic          asyncTrig;
  logic [NS-1:0] syncSrc;
  logic          scanBusy;
  logic          startA;
  logic          startB;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  adc_start_sel #(.NUM_SRC(NS), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .trgEnable(trgEnable), .extSelect(extSelect),
    .scanMode(scanMode), .swStart(swStart), .asyncTrig(asyncTrig),
    .syncSrc(syncSrc), .scanBusy(scanBusy), .startA(startA), .startB(startB)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearTrig();
    swStart = 1'b0; asyncTrig = 1'b0; syncSrc = '0; scanBusy = 1'b0;
  endtask

  task automatic idle();
    clearTrig();
    step(); step();
  endtask

  task automatic wrReg(input logic [15:0] v);
    regWrEn = 1'b1; regWrData = v;
    step();
    regWrEn = 1'b0;
  endtask

  function automatic logic [15:0] both();
    return {14'd0, startB, startA};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    $display("watchdog expired");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0;
    trgEnable = 1'b1; extSelect = 1'b0; scanMode = 2'b00;
    swStart = 1'b1; asyncTrig = 1'b0; syncSrc = '1; scanBusy = 1'b0;
    repeat (3) step();
    chk("R1 reset reg", regRdData, 16'h0000);
    chk("R1 reset starts", both(), 16'h0);
    clearTrig();
    rstN = 1'b1;
    step();
    chk("R1 after reset", both(), 16'h0);

    // R2 register masking
    foreach (u0.regRdData[i]) begin
      wrReg(16'h1 << i);
      chk("R2 onehot", regRdData, (16'h1 << i) & 16'h3F3F);
    end
    wrReg(16'hFFFF); chk("R2 ones", regRdData, 16'h3F3F);
    wrReg(16'hA5C3); chk("R2 mix", regRdData, 16'h2503);
    idle();

    // R4 sweep over all group A codes, enable/select combos
    for (int sel = 0; sel < 64; sel++) begin
      scanMode = 2'(sel % 3);
      wrReg({2'b00, 6'(sel), 8'h00});
      for (int en = 0; en < 2; en++) begin
        for (int ex = 0; ex < 2; ex++) begin
          for (int hit = 0; hit < 2; hit++) begin
            trgEnable = en[0]; extSelect = ex[0];
            syncSrc = '0;
            syncSrc[hit != 0 ? sel : (sel + 1) % 64] = 1'b1;
            step();
            chk("R4 sync A", both(),
                {15'd0, (en == 1 && ex == 0 && hit == 1) ? 1'b1 : 1'b0});
            idle();
          end
        end
      end
    end

    // R3 software start bypasses gating
    scanMode = 2'b00;
    for (int c = 0; c < 4; c++) begin
      wrReg({2'b00, 6'(c * 13), 8'h00});
      trgEnable = c[0]; extSelect = c[1];
      swStart = 1'b1;
      step();
      chk("R3 sw start", both(), 16'h1);
      idle();
    end

    // R5 asynchronous edge, three edges of latency, one pulse
    wrReg(16'h0000);
    trgEnable = 1'b1; extSelect = 1'b1;
    idle();
    asyncTrig = 1'b1;
    step(); chk("R5 async edge1", both(), 16'h0);
    step(); chk("R5 async edge2", both(), 16'h0);
    step(); chk("R5 async edge3", both(), 16'h1);
    step(); chk("R5 async held", both(), 16'h0);
    step(); step(); chk("R5 async held long", both(), 16'h0);
    asyncTrig = 1'b0; step(); step();
    extSelect = 1'b0; asyncTrig = 1'b1;
    step(); step(); step(); chk("R5 async ignored ext0", both(), 16'h0);
    step(); chk("R5 async ignored ext0 late", both(), 16'h0);
    idle(); step(); step();

    // R6/R7/R8 group B code and mode sweep
    trgEnable = 1'b1; extSelect = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [5:0] codeB;
        codeB = (k == 0) ? 6'd0 : ((k == 1) ? 6'd5 : 6'd62);
        scanMode = 2'b00;
        wrReg({2'b00, 6'd40, 2'b00, codeB});
        idle();
        scanMode = 2'(m);
        syncSrc[codeB] = 1'b1;
        step();
        chk((k == 0) ? "R7 code zero B" : "R6 B mode gating", both(),
            {14'd0, (m == 2 && k != 0) ? 1'b1 : 1'b0, 1'b0});
        idle();
        scanMode = 2'b00;
        step();
      end
    end
    // R8 source-driven B needs extSelect=0
    scanMode = 2'b00; wrReg(16'h2805); scanMode = 2'b10;
    extSelect = 1'b1; syncSrc[5] = 1'b1;
    step(); chk("R8 B blocked by ext", both(), 16'h0);
    extSelect = 1'b0; idle();
    // R7 software/async never reach B
    swStart = 1'b1; step(); chk("R7 sw to A only", both(), 16'h1);
    idle();
    extSelect = 1'b1; asyncTrig = 1'b1;
    step(); step(); step(); chk("R7 async to A only", both(), 16'h1);
    idle(); extSelect = 1'b0; scanMode = 2'b00; step();

    // R8 auto-restart code
    wrReg(16'h283F);
    scanMode = 2'b10; trgEnable = 1'b1;
    step(); chk("R8 auto B", both(), 16'h2);
    step(); chk("R11 auto B holdoff", both(), 16'h0);
    step(); chk("R8 auto B again", both(), 16'h2);
    trgEnable = 1'b0;
    step(); step(); chk("R8 auto needs enable", both(), 16'h0);
    trgEnable = 1'b1; scanMode = 2'b00;
    step(); step(); chk("R6 auto off outside group", both(), 16'h0);

    // R9 busy drops, no memory
    wrReg(16'h0900);
    scanBusy = 1'b1; syncSrc[9] = 1'b1;
    step(); chk("R9 busy sync", both(), 16'h0);
    swStart = 1'b1;
    step(); chk("R9 busy sw", both(), 16'h0);
    scanBusy = 1'b0; swStart = 1'b0; syncSrc = '0;
    step(); chk("R9 not queued", both(), 16'h0);
    step(); chk("R9 not queued late", both(), 16'h0);

    // R10 A wins, B dropped
    wrReg(16'h0304); scanMode = 2'b10;
    syncSrc[3] = 1'b1; syncSrc[4] = 1'b1;
    step(); chk("R10 A wins", both(), 16'h1);
    syncSrc = '0;
    step(); chk("R11 holdoff after A", both(), 16'h0);
    step(); chk("R10 B not queued", both(), 16'h0);
    syncSrc[4] = 1'b1;
    step(); chk("R10 B alone", both(), 16'h2);
    step(); chk("R11 B held src single pulse", both(), 16'h0);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule